// File: doc/BRIEF.md
# RTC Alarm and Counter-Increment Interrupt Unit

This unit produces the interrupt for a real-time clock that keeps eight time counters: seconds, minutes, hours, day of month, day of week, day of year, month and year. The timekeeping logic supplies the current value of each counter and a one-cycle strobe each time a counter advances. The unit raises its interrupt from either of two sources. The first is an increment of any counter that software has selected. The second is an alarm, which fires when every alarm field that is not masked equals its counter.

Software controls the unit through a small word-addressed register bus. The registers are a status word with write-one-to-clear bits, an increment-select word, an alarm mask word and eight alarm values. Field index i refers to the same counter in every register and on every input: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 day of year, 6 month, 7 year. The rst_n input affects only the alarm entry tracker. The configuration and status registers keep their contents through reset, and software must initialise them.

The alarm entry tracker is a two-state machine. In state AW_OUT the counters are outside the alarm condition. In state AW_IN the alarm condition holds. The transition AW_OUT to AW_IN is taken when the masked compare matches, and it emits the one-cycle alarm event. The transition AW_IN to AW_OUT is taken when the match goes away. Each state loops on itself otherwise. Reset forces AW_OUT.

Top module: `rtc_irq_unit`

## Requirements
- R1: When cnt_inc[i] is high in a cycle while increment-select bit i is set, status bit 0 reads 1 from the next cycle.
- R2: A strobe on a counter whose increment-select bit is clear leaves status bit 0 unchanged.
- R3: When the counters enter a state where every unmasked field equals its alarm value, status bit 1 reads 1 from the next cycle.
- R4: When mask bit i is set, field i is left out of the alarm compare.
- R5: When all eight mask bits are set, no alarm event occurs, even if the values match.
- R6: An alarm match that persists does not set status bit 1 again after it is cleared. The match must first end and then return.
- R7: A write to byte offset 0x00 clears each status bit whose written bit is 1 (bit 0 increment, bit 1 alarm). Written 0 bits have no effect.
- R8: If an event and a clear for the same status bit occur in the same cycle, the bit stays set.
- R9: irq is high whenever either status bit is set, and it falls only after a clearing write.
- R10: rst_n leaves the configuration and status registers unchanged and returns the tracker to AW_OUT, so a match present when reset is released counts as a new entry.
- R11: The register map uses these byte offsets: status at 0x00, increment select at 0x0C, alarm mask at 0x10, and alarm value i at 0x14 + 4*i. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the alarm entry tracker only |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address (low two bits ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| cnt_val | input | 96 | Counter values, field i in bits [12i+11:12i] |
| cnt_inc | input | 8 | One-cycle increment strobe per counter |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each cnt_inc bit is a single-cycle pulse per increment and that cnt_val changes only on clock edges. They also assume that software clears status only through bus writes at offset 0x00. The bench drives the strobes and counter values at the falling edge, holds each strobe for exactly one cycle and changes counters in whole cycles. It clears both status bits before it relies on them, because reset does not initialise them. Each alarm scenario first leaves the match state before it tests a new entry.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    // Alarm entry tracker states
    typedef enum logic {
        AW_OUT = 1'b0,
        AW_IN  = 1'b1
    } alm_state_e;

    // Word indices (byte offset / 4)
    localparam int unsigned WIDX_STATUS = 0;
    localparam int unsigned WIDX_INCSEL = 3;
    localparam int unsigned WIDX_MASK   = 4;
    localparam int unsigned WIDX_ALARM0 = 5;

    // Status bit positions
    localparam int unsigned SB_INC = 0;
    localparam int unsigned SB_ALM = 1;

endpackage

// File: rtl/rtc_irq_regfile.sv
module rtc_irq_regfile
    import rtc_irq_pkg::*;
#(
    parameter int N_CNT   = 8,
    parameter int FIELD_W = 12,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic                     st_inc,
    input  logic                     st_alm,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [N_CNT-1:0]         inc_sel,
    output logic [N_CNT-1:0]         alm_mask,
    output logic [N_CNT*FIELD_W-1:0] alm_val,
    output logic                     clr_inc,
    output logic                     clr_alm
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]  word;
    logic               wr_en;
    logic [FIELD_W-1:0] alm_q [N_CNT];
    logic               unused_bits;

    assign word        = bus_addr[ADDR_W-1:2];
    assign wr_en       = bus_sel && bus_wr;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:FIELD_W]};

    // Clear requests (R7)
    assign clr_inc = wr_en && (word == WORD_W'(WIDX_STATUS)) && bus_wdata[SB_INC];
    assign clr_alm = wr_en && (word == WORD_W'(WIDX_STATUS)) && bus_wdata[SB_ALM];

    // Configuration registers: not reset (R10)
    always_ff @(posedge clk) begin
        if (wr_en && (word == WORD_W'(WIDX_INCSEL))) begin
            inc_sel <= bus_wdata[N_CNT-1:0];
        end
        if (wr_en && (word == WORD_W'(WIDX_MASK))) begin
            alm_mask <= bus_wdata[N_CNT-1:0];
        end
    end

    for (genvar g = 0; g < N_CNT; g++) begin : g_alarm
        always_ff @(posedge clk) begin
            if (wr_en && (word == WORD_W'(WIDX_ALARM0 + g))) begin
                alm_q[g] <= bus_wdata[FIELD_W-1:0];
            end
        end
        assign alm_val[g*FIELD_W +: FIELD_W] = alm_q[g];
    end

    // Read mux (R11)
    always_comb begin
        bus_rdata = '0;
        if (word == WORD_W'(WIDX_STATUS)) begin
            bus_rdata[SB_INC] = st_inc;
            bus_rdata[SB_ALM] = st_alm;
        end else if (word == WORD_W'(WIDX_INCSEL)) begin
            bus_rdata[N_CNT-1:0] = inc_sel;
        end else if (word == WORD_W'(WIDX_MASK)) begin
            bus_rdata[N_CNT-1:0] = alm_mask;
        end else begin
            for (int i = 0; i < N_CNT; i++) begin
                if (word == WORD_W'(WIDX_ALARM0 + i)) begin
                    bus_rdata[FIELD_W-1:0] = alm_q[i];
                end
            end
        end
    end

endmodule

// File: rtl/rtc_alarm_edge.sv
module rtc_alarm_edge
    import rtc_irq_pkg::*;
#(
    parameter int N_CNT   = 8,
    parameter int FIELD_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CNT*FIELD_W-1:0] cnt_val,
    input  logic [N_CNT*FIELD_W-1:0] alm_val,
    input  logic [N_CNT-1:0]         alm_mask,
    output logic                     alm_rise
);
    logic [N_CNT-1:0] fld_ok;
    logic             match;
    alm_state_e       state_q, state_d;

    // Per-field compare, masked fields always pass (R4)
    for (genvar g = 0; g < N_CNT; g++) begin : g_cmp
        assign fld_ok[g] = alm_mask[g] ||
            (cnt_val[g*FIELD_W +: FIELD_W] == alm_val[g*FIELD_W +: FIELD_W]);
    end

    // Fully masked compare never matches (R5)
    assign match = (&fld_ok) && !(&alm_mask);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AW_OUT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AW_OUT: if (match)  state_d = AW_IN;
            AW_IN:  if (!match) state_d = AW_OUT;
            default: state_d = AW_OUT;
        endcase
    end

    // Output: event only on entry (R3, R6)
    always_comb begin
        alm_rise = 1'b0;
        unique case (state_q)
            AW_OUT:  alm_rise = match;
            AW_IN:   alm_rise = 1'b0;
            default: alm_rise = 1'b0;
        endcase
    end

    a_r6_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        alm_rise |=> !alm_rise);

    a_r5_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&alm_mask) |-> !alm_rise);

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
    import rtc_irq_pkg::*;
#(
    parameter int N_CNT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CNT-1:0] cnt_inc,
    input  logic [N_CNT-1:0] inc_sel,
    input  logic             alm_rise,
    input  logic             clr_inc,
    input  logic             clr_alm,
    output logic             st_inc,
    output logic             st_alm,
    output logic             irq
);
    logic inc_evt;

    assign inc_evt = |(cnt_inc & inc_sel);

    // Status latches: not reset (R10); event wins over clear (R8)
    always_ff @(posedge clk) begin
        if (inc_evt)      st_inc <= 1'b1;
        else if (clr_inc) st_inc <= 1'b0;

        if (alm_rise)     st_alm <= 1'b1;
        else if (clr_alm) st_alm <= 1'b0;
    end

    assign irq = st_inc | st_alm;

    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        inc_evt |=> st_inc);

    a_r7_clear_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_inc && !inc_evt) |=> !st_inc);

    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_evt && !clr_inc) |=> $stable(st_inc));

    a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr_inc || clr_alm));

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_irq_pkg::*;
#(
    parameter int N_CNT   = 8,
    parameter int FIELD_W = 12,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [N_CNT*FIELD_W-1:0] cnt_val,
    input  logic [N_CNT-1:0]         cnt_inc,
    output logic                     irq
);
    logic [N_CNT-1:0]         inc_sel;
    logic [N_CNT-1:0]         alm_mask;
    logic [N_CNT*FIELD_W-1:0] alm_val;
    logic                     clr_inc, clr_alm;
    logic                     st_inc, st_alm;
    logic                     alm_rise;

    rtc_irq_regfile #(
        .N_CNT(N_CNT), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .st_inc(st_inc), .st_alm(st_alm),
        .bus_rdata(bus_rdata), .inc_sel(inc_sel), .alm_mask(alm_mask),
        .alm_val(alm_val), .clr_inc(clr_inc), .clr_alm(clr_alm)
    );

    rtc_alarm_edge #(
        .N_CNT(N_CNT), .FIELD_W(FIELD_W)
    ) u_alarm (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .alm_val(alm_val),
        .alm_mask(alm_mask), .alm_rise(alm_rise)
    );

    rtc_irq_status #(
        .N_CNT(N_CNT)
    ) u_status (
        .clk(clk), .rst_n(rst_n), .cnt_inc(cnt_inc), .inc_sel(inc_sel),
        .alm_rise(alm_rise), .clr_inc(clr_inc), .clr_alm(clr_alm),
        .st_inc(st_inc), .st_alm(st_alm), .irq(irq)
    );

endmodule

// File: tb/tb_rtc_irq_unit.sv
module tb_rtc_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_CNT = 8;
    localparam int FW    = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [N_CNT*FW-1:0] cnt_val;
    logic [N_CNT-1:0]  cnt_inc = '0;
    logic              irq;
    logic [FW-1:0]     cv [N_CNT];

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N_CNT; i++) cnt_val[i*FW +: FW] = cv[i];
    end

    rtc_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_val(cnt_val), .cnt_inc(cnt_inc), .irq(irq)
    );

    // {incsel, strobe, expected status bit 0}
    localparam logic [16:0] VEC [8] = '{
        {8'h01, 8'h01, 1'b1}, {8'h01, 8'h02, 1'b0},
        {8'h80, 8'h80, 1'b1}, {8'hFF, 8'h00, 1'b0},
        {8'h00, 8'hFF, 1'b0}, {8'h0F, 8'hF0, 1'b0},
        {8'h24, 8'h04, 1'b1}, {8'h24, 8'h21, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdr(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] s);
        @(negedge clk);
        cnt_inc = s;
        @(negedge clk);
        cnt_inc = '0;
    endtask

    task automatic setc(input int i, input logic [FW-1:0] v);
        @(negedge clk);
        cv[i] = v;
    endtask

    initial begin
        for (int i = 0; i < N_CNT; i++) cv[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Park alarm, then clear status: cleared state (R7, R9)
        wr(8'h10, 32'hFF);
        wr(8'h00, 32'h3);
        rdr(8'h00, rd); chk("R7 cleared status", rd, 32'h0);
        chk("R9 irq low when clear", {31'b0, irq}, 32'h0);

        // Increment vector table (R1, R2)
        for (int v = 0; v < 8; v++) begin
            wr(8'h0C, {24'b0, VEC[v][16:9]});
            wr(8'h00, 32'h1);
            pulse(VEC[v][8:1]);
            rdr(8'h00, rd);
            chk(VEC[v][0] ? "R1 selected increment" : "R2 unselected increment",
                {31'b0, rd[0]}, {31'b0, VEC[v][0]});
        end

        // Alarm setup
        for (int i = 0; i < N_CNT; i++) wr(8'h14 + 8'(4*i), 32'h10 + i);
        wr(8'h00, 32'h3);
        wr(8'h10, 32'h00);
        @(negedge clk);
        for (int i = 0; i < N_CNT; i++) cv[i] = FW'(16 + i);
        rdr(8'h00, rd); chk("R3 alarm entry", rd, 32'h2);
        chk("R9 irq high", {31'b0, irq}, 32'h1);

        // Persisting match no retrigger (R6)
        wr(8'h00, 32'h2);
        rdr(8'h00, rd); chk("R6 no retrigger", rd, 32'h0);
        repeat (3) @(negedge clk);
        rdr(8'h00, rd); chk("R6 still clear", rd, 32'h0);
        setc(0, 12'h000);
        setc(0, 12'h010);
        rdr(8'h00, rd); chk("R6 re-entry", rd, 32'h2);

        // Masked field (R4)
        wr(8'h00, 32'h2);
        setc(1, 12'h000);
        wr(8'h10, 32'h01);
        setc(0, 12'h005);
        rdr(8'h00, rd); chk("R4 no match yet", rd, 32'h0);
        setc(1, 12'h011);
        rdr(8'h00, rd); chk("R4 masked field ignored", rd, 32'h2);

        // All masked (R5)
        wr(8'h00, 32'h2);
        setc(1, 12'h000);
        wr(8'h10, 32'hFF);
        setc(1, 12'h011);
        setc(0, 12'h010);
        repeat (2) @(negedge clk);
        rdr(8'h00, rd); chk("R5 all masked", rd, 32'h0);
        chk("R5 irq low", {31'b0, irq}, 32'h0);

        // Reset retention and re-arm (R10)
        wr(8'h10, 32'h00);
        rdr(8'h00, rd); chk("R3 entry after unmask", rd, 32'h2);
        wr(8'h00, 32'h2);
        wr(8'h0C, 32'hA5);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rdr(8'h00, rd); chk("R10 re-armed after reset", rd, 32'h2);
        rdr(8'h0C, rd); chk("R10 incsel kept", rd, 32'hA5);

        // Register map (R11)
        rdr(8'h10, rd); chk("R11 mask offset", rd, 32'h0);
        rdr(8'h30, rd); chk("R11 alarm 7 offset", rd, 32'h17);
        rdr(8'h04, rd); chk("R11 unmapped read", rd, 32'h0);

        // Write-one-to-clear selectivity (R7)
        pulse(8'h01);
        rdr(8'h00, rd); chk("R7 both set", rd, 32'h3);
        wr(8'h00, 32'h1);
        rdr(8'h00, rd); chk("R7 clear bit0 only", rd, 32'h2);
        wr(8'h00, 32'h0);
        rdr(8'h00, rd); chk("R7 zero no effect", rd, 32'h2);
        wr(8'h00, 32'h2);
        rdr(8'h00, rd); chk("R7 clear bit1", rd, 32'h0);
        chk("R9 irq falls after clear", {31'b0, irq}, 32'h0);

        // Event beats clear (R8)
        pulse(8'h01);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h1;
        cnt_inc = 8'h01;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; cnt_inc = '0;
        rdr(8'h00, rd); chk("R8 event wins", {31'b0, rd[0]}, 32'h1);
        chk("R9 irq held", {31'b0, irq}, 32'h1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule